// File: doc/BRIEF.md
# Virtual Segment Mapper with Fault Capture

This block stands between the load/store pipeline and the TLB. It takes a 32-bit virtual address and decides how to translate it from the address's top bits, the user-mode flag and the error-level flag. Two kernel windows are translated here by subtracting a fixed base. The user region, when the error level is clear, is sent to the TLB. The upper kernel region is always sent to the TLB. In user mode, any address with bit 31 set is rejected at once.

The TLB answers in the same cycle with a match bit, a valid bit, a dirty bit and a physical address. The block turns that answer into either a translated address or a fault. A fault carries an exception code and a refill flag. On the clock edge in which the fault strobe is high, the block loads three capture registers: the faulting address, a page-table context word and an entry-high word. The context word keeps its page-table base bits. The entry-high word keeps its address-space identifier.

Top module: `vseg_mapper`

## Requirements
- R1: After reset, `bad_vaddr` is 0, `ctx_reg` is `{CTX_BASE_RST, 23'b0}` and `entry_hi` is `ASID_RST` zero-extended. With `req_valid` low, `fault`, `xlat_ok` and `tlb_req` are all 0.
- R2: In user mode, a request whose address has bit 31 set faults. The code is 4 for a load and 5 for a store, `fault_refill` is 0 and `tlb_req` stays low.
- R3: With `err_level` high, an address below 0x80000000 translates to itself with `xlat_ok` high, and `tlb_req` stays low.
- R4: An address from 0x80000000 to 0x9FFFFFFF translates to the address minus 0x80000000, with no TLB request.
- R5: An address from 0xA0000000 to 0xBFFFFFFF translates to the address minus 0xA0000000, with no TLB request.
- R6: An address of 0xC0000000 or above, whatever `err_level` is, raises `tlb_req` with `tlb_vaddr` equal to the address. So does an address below 0x80000000 while `err_level` is low. When the TLB result is a valid match, the output is `tlb_paddr` with `xlat_ok` high.
- R7: A TLB miss faults with code 2 for a load or 3 for a store, and `fault_refill` is 1.
- R8: A TLB match whose valid bit is clear faults with code 2 for a load or 3 for a store, and `fault_refill` is 0.
- R9: A store that hits a valid entry whose dirty bit is clear faults with code 1 and `fault_refill` 0. A load to the same entry translates normally.
- R10: On the clock edge where `fault` is high, `bad_vaddr` takes the faulting address.
- R11: On that edge, `ctx_reg` keeps bits 31:23 and its bits 22:0 become `(vaddr >> 9) & 32'h007FFFF0`.
- R12: On that edge, `entry_hi` keeps bits `ASID_W-1:0`. Its bits 31 down to `PAGE_BITS+1` take the same bits of the address, and the bits between are 0.
- R13: An idle cycle, or a cycle with a successful translation, leaves all three capture registers unchanged. `fault` and `xlat_ok` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A translation request is present |
| req_vaddr | input | 32 | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load |
| mode_user | input | 1 | Requester runs in user mode |
| err_level | input | 1 | Error-level flag; makes the low region identity-mapped |
| tlb_req | output | 1 | The address needs a TLB lookup |
| tlb_vaddr | output | 32 | Address presented to the TLB |
| tlb_match | input | 1 | TLB found an entry for the address |
| tlb_valid | input | 1 | Valid bit of the selected page half |
| tlb_dirty | input | 1 | Dirty (write-enable) bit of the selected page half |
| tlb_paddr | input | 32 | Physical address from the TLB |
| xlat_ok | output | 1 | Translation succeeded |
| xlat_paddr | output | 32 | Physical address |
| fault | output | 1 | Translation failed this cycle |
| fault_code | output | 5 | Exception code (1 modify, 2 TLB load, 3 TLB store, 4 address load, 5 address store) |
| fault_refill | output | 1 | Fault came from a TLB miss |
| bad_vaddr | output | 32 | Captured faulting address |
| ctx_reg | output | 32 | Captured context word |
| entry_hi | output | 32 | Captured entry-high word |

## Verification
The bench sets `PAGE_BITS` to 12, `ASID_W` to 8, `ASID_RST` to 8'h5A and `CTX_BASE_RST` to 9'h157. Because the preserved fields reset to non-zero patterns, any update that overwrites them shows up as a wrong value. The 13-bit page-pair boundary puts a zero gap between the identifier and the captured address bits of `entry_hi`. The bench checks that gap with an address whose bits 12:8 are all ones.

// File: rtl/vsm_pkg.sv
package vsm_pkg;

    localparam int VA_W = 32;
    localparam logic [VA_W-1:0] KS0_BASE = 32'h8000_0000;
    localparam logic [VA_W-1:0] KS1_BASE = 32'hA000_0000;

    typedef enum logic [1:0] {
        SEG_LOW  = 2'd0,
        SEG_KS0  = 2'd1,
        SEG_KS1  = 2'd2,
        SEG_HIGH = 2'd3
    } seg_e;

    typedef enum logic [4:0] {
        EXC_NONE = 5'd0,
        EXC_MOD  = 5'd1,
        EXC_TLBL = 5'd2,
        EXC_TLBS = 5'd3,
        EXC_ADEL = 5'd4,
        EXC_ADES = 5'd5
    } exc_e;

    typedef struct packed {
        logic            ok;
        logic            fault;
        exc_e            code;
        logic            refill;
        logic [VA_W-1:0] paddr;
    } xlat_res_t;

    function automatic seg_e seg_of(input logic [VA_W-1:0] va);
        if (!va[31])         return SEG_LOW;
        else if (!va[30])    return va[29] ? SEG_KS1 : SEG_KS0;
        else                 return SEG_HIGH;
    endfunction

    function automatic exc_e tlb_code(input logic store);
        return store ? EXC_TLBS : EXC_TLBL;
    endfunction

endpackage

// File: rtl/vsm_seg_decode.sv
module vsm_seg_decode
    import vsm_pkg::*;
(
    input  logic            valid,
    input  logic [VA_W-1:0] vaddr,
    input  logic            user,
    input  logic            erl,
    output logic            addr_err,
    output logic            mapped,
    output logic            direct,
    output logic [VA_W-1:0] direct_paddr
);
    seg_e seg;

    always_comb begin
        seg          = seg_of(vaddr);
        addr_err     = 1'b0;
        mapped       = 1'b0;
        direct       = 1'b0;
        direct_paddr = '0;
        if (valid) begin
            if (user && vaddr[31]) begin
                addr_err = 1'b1;
            end else begin
                unique case (seg)
                    SEG_LOW: begin
                        if (erl) begin
                            direct       = 1'b1;
                            direct_paddr = vaddr;
                        end else begin
                            mapped = 1'b1;
                        end
                    end
                    SEG_KS0: begin
                        direct       = 1'b1;
                        direct_paddr = vaddr - KS0_BASE;
                    end
                    SEG_KS1: begin
                        direct       = 1'b1;
                        direct_paddr = vaddr - KS1_BASE;
                    end
                    default: mapped = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/vsm_tlb_judge.sv
module vsm_tlb_judge
    import vsm_pkg::*;
(
    input  logic            lookup,
    input  logic            store,
    input  logic            hit,
    input  logic            page_valid,
    input  logic            page_dirty,
    input  logic [VA_W-1:0] page_paddr,
    output xlat_res_t       res
);
    always_comb begin
        res = '{ok: 1'b0, fault: 1'b0, code: EXC_NONE, refill: 1'b0, paddr: '0};
        if (lookup) begin
            if (!hit) begin
                res.fault  = 1'b1;
                res.code   = tlb_code(store);
                res.refill = 1'b1;
            end else if (!page_valid) begin
                res.fault = 1'b1;
                res.code  = tlb_code(store);
            end else if (store && !page_dirty) begin
                res.fault = 1'b1;
                res.code  = EXC_MOD;
            end else begin
                res.ok    = 1'b1;
                res.paddr = page_paddr;
            end
        end
    end
endmodule

// File: rtl/vsm_fault_regs.sv
module vsm_fault_regs
    import vsm_pkg::*;
#(
    parameter int                 PAGE_BITS    = 12,
    parameter int                 ASID_W       = 8,
    parameter logic [ASID_W-1:0]  ASID_RST     = '0,
    parameter logic [8:0]         CTX_BASE_RST = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            capture,
    input  logic [VA_W-1:0] vaddr,
    output logic [VA_W-1:0] bad_q,
    output logic [VA_W-1:0] ctx_q,
    output logic [VA_W-1:0] ehi_q
);
    localparam int              PAIR_SHIFT = PAGE_BITS + 1;
    localparam logic [VA_W-1:0] VPN2_MASK  = ~((32'd1 << PAIR_SHIFT) - 32'd1);
    localparam logic [VA_W-1:0] ASID_MASK  = (32'd1 << ASID_W) - 32'd1;

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_q <= '0;
            ctx_q <= {CTX_BASE_RST, 23'b0};
            ehi_q <= VA_W'(ASID_RST);
        end else if (capture) begin
            bad_q <= vaddr;
            ctx_q <= {ctx_q[31:23], vaddr[31:13], 4'b0000};
            ehi_q <= (vaddr & VPN2_MASK) | (ehi_q & ASID_MASK);
        end
    end

    a_r10_badva_load: assert property (@(posedge clk) disable iff (rst)
        capture |=> bad_q == $past(vaddr));

    a_r11_ctx_base_kept: assert property (@(posedge clk) disable iff (rst)
        $stable(ctx_q[31:23]));

    a_r12_asid_kept: assert property (@(posedge clk) disable iff (rst)
        $stable(ehi_q[ASID_W-1:0]));

    a_r13_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(bad_q) && $stable(ctx_q) && $stable(ehi_q));
endmodule

// File: rtl/vseg_mapper.sv
module vseg_mapper
    import vsm_pkg::*;
#(
    parameter int                PAGE_BITS    = 12,
    parameter int                ASID_W       = 8,
    parameter logic [ASID_W-1:0] ASID_RST     = '0,
    parameter logic [8:0]        CTX_BASE_RST = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_vaddr,
    input  logic        req_store,
    input  logic        mode_user,
    input  logic        err_level,
    output logic        tlb_req,
    output logic [31:0] tlb_vaddr,
    input  logic        tlb_match,
    input  logic        tlb_valid,
    input  logic        tlb_dirty,
    input  logic [31:0] tlb_paddr,
    output logic        xlat_ok,
    output logic [31:0] xlat_paddr,
    output logic        fault,
    output logic [4:0]  fault_code,
    output logic        fault_refill,
    output logic [31:0] bad_vaddr,
    output logic [31:0] ctx_reg,
    output logic [31:0] entry_hi
);
    logic            addr_err, mapped, direct;
    logic [VA_W-1:0] direct_paddr;
    xlat_res_t       tlb_res, res;

    vsm_seg_decode u_seg (
        .valid        (req_valid),
        .vaddr        (req_vaddr),
        .user         (mode_user),
        .erl          (err_level),
        .addr_err     (addr_err),
        .mapped       (mapped),
        .direct       (direct),
        .direct_paddr (direct_paddr)
    );

    vsm_tlb_judge u_judge (
        .lookup     (mapped),
        .store      (req_store),
        .hit        (tlb_match),
        .page_valid (tlb_valid),
        .page_dirty (tlb_dirty),
        .page_paddr (tlb_paddr),
        .res        (tlb_res)
    );

    always_comb begin
        res = '{ok: 1'b0, fault: 1'b0, code: EXC_NONE, refill: 1'b0, paddr: '0};
        if (addr_err) begin
            res.fault = 1'b1;
            res.code  = req_store ? EXC_ADES : EXC_ADEL;
        end else if (mapped) begin
            res = tlb_res;
        end else if (direct) begin
            res.ok    = 1'b1;
            res.paddr = direct_paddr;
        end
    end

    assign tlb_req      = mapped;
    assign tlb_vaddr    = req_vaddr;
    assign xlat_ok      = res.ok;
    assign xlat_paddr   = res.paddr;
    assign fault        = res.fault;
    assign fault_code   = res.code;
    assign fault_refill = res.refill;

    vsm_fault_regs #(
        .PAGE_BITS    (PAGE_BITS),
        .ASID_W       (ASID_W),
        .ASID_RST     (ASID_RST),
        .CTX_BASE_RST (CTX_BASE_RST)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .capture (res.fault),
        .vaddr   (req_vaddr),
        .bad_q   (bad_vaddr),
        .ctx_q   (ctx_reg),
        .ehi_q   (entry_hi)
    );

    a_r2_user_high_rejected: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mode_user && req_vaddr[31]) |->
            (!tlb_req && fault && !fault_refill &&
             (fault_code == EXC_ADEL || fault_code == EXC_ADES)));

    a_r7_refill_is_tlb_code: assert property (@(posedge clk) disable iff (rst)
        fault_refill |-> (fault && (fault_code == EXC_TLBL || fault_code == EXC_TLBS)));

    a_r9_mod_only_store: assert property (@(posedge clk) disable iff (rst)
        (fault && fault_code == EXC_MOD) |-> (req_store && tlb_req && tlb_match));

    a_r13_ok_fault_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(fault && xlat_ok));

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!fault && !xlat_ok && !tlb_req));
endmodule

// File: tb/sim_vseg_mapper.sv
`timescale 1ns/100ps
module sim_vseg_mapper;
    localparam logic [7:0] ASID_RST = 8'h5A;
    localparam logic [8:0] CTX_BASE = 9'h157;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_store, mode_user, err_level;
    logic [31:0] req_vaddr;
    logic        tlb_req;
    logic [31:0] tlb_vaddr;
    logic        tlb_match, tlb_valid, tlb_dirty;
    logic [31:0] tlb_paddr;
    logic        xlat_ok, fault, fault_refill;
    logic [31:0] xlat_paddr, bad_vaddr, ctx_reg, entry_hi;
    logic [4:0]  fault_code;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_bad, m_ctx, m_ehi;

    always #2.5 clk = ~clk;

    vseg_mapper #(.PAGE_BITS(12), .ASID_W(8), .ASID_RST(ASID_RST), .CTX_BASE_RST(CTX_BASE)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .mode_user(mode_user), .err_level(err_level),
        .tlb_req(tlb_req), .tlb_vaddr(tlb_vaddr), .tlb_match(tlb_match),
        .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty), .tlb_paddr(tlb_paddr),
        .xlat_ok(xlat_ok), .xlat_paddr(xlat_paddr), .fault(fault),
        .fault_code(fault_code), .fault_refill(fault_refill),
        .bad_vaddr(bad_vaddr), .ctx_reg(ctx_reg), .entry_hi(entry_hi));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [31:0] va, input logic st, input logic usr, input logic erl,
                         input logic m, input logic v, input logic d, input logic [31:0] pa);
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_store = st; mode_user = usr; err_level = erl;
        tlb_match = m; tlb_valid = v; tlb_dirty = d; tlb_paddr = pa;
        #1;
    endtask

    // Let the edge pass, then compare the capture registers with the model.
    task automatic finish_req(input string req, input logic was_fault);
        logic [31:0] va;
        va = req_vaddr;
        if (was_fault) begin
            m_bad = va;
            m_ctx = (m_ctx & 32'hFF80_0000) | ((va >> 9) & 32'h007F_FFF0);
            m_ehi = (va & 32'hFFFF_E000) | (m_ehi & 32'h0000_00FF);
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
        chk({req, " bad_vaddr"}, bad_vaddr, m_bad);
        chk({req, " ctx_reg"},   ctx_reg,   m_ctx);
        chk({req, " entry_hi"},  entry_hi,  m_ehi);
    endtask

    task automatic t_reset;
        rst = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_store = 1'b0;
        mode_user = 1'b0; err_level = 1'b0; tlb_match = 1'b0; tlb_valid = 1'b0;
        tlb_dirty = 1'b0; tlb_paddr = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m_bad = '0; m_ctx = {CTX_BASE, 23'b0}; m_ehi = {24'b0, ASID_RST};
        @(negedge clk);
        chk("R1 bad_vaddr", bad_vaddr, m_bad);
        chk("R1 ctx_reg", ctx_reg, m_ctx);
        chk("R1 entry_hi", entry_hi, m_ehi);
        chk("R1 idle outs", {29'b0, fault, xlat_ok, tlb_req}, 32'd0);
    endtask

    task automatic t_user_adderr;
        drive(32'h8000_1234, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0);
        chk("R2 load code", {27'b0, fault_code}, 32'd4);
        chk("R2 fault/refill/tlbreq", {29'b0, fault, fault_refill, tlb_req}, 32'b100);
        finish_req("R2 R10 R11 R12 load", 1'b1);
        drive(32'hC123_4F00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0);
        chk("R2 store code", {27'b0, fault_code}, 32'd5);
        finish_req("R2 R10 R11 R12 store", 1'b1);
    endtask

    task automatic t_erl_identity;
        drive(32'h1234_5678, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'hDEAD_0000);
        chk("R3 paddr", xlat_paddr, 32'h1234_5678);
        chk("R3 ok/tlbreq", {30'b0, xlat_ok, tlb_req}, 32'b10);
        finish_req("R3 R13", 1'b0);
    endtask

    task automatic t_kseg;
        drive(32'h9FFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R4 paddr", xlat_paddr, 32'h1FFF_FFFC);
        chk("R4 ok/tlbreq", {30'b0, xlat_ok, tlb_req}, 32'b10);
        finish_req("R4 R13", 1'b0);
        drive(32'hA000_0010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R5 paddr", xlat_paddr, 32'h0000_0010);
        chk("R5 ok/tlbreq", {30'b0, xlat_ok, tlb_req}, 32'b10);
        finish_req("R5 R13", 1'b0);
    endtask

    task automatic t_tlb_hit;
        drive(32'h0040_1000, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0770_1000);
        chk("R6 low tlbreq", {31'b0, tlb_req}, 32'd1);
        chk("R6 tlb_vaddr", tlb_vaddr, 32'h0040_1000);
        chk("R6 paddr", xlat_paddr, 32'h0770_1000);
        chk("R6 ok", {31'b0, xlat_ok}, 32'd1);
        finish_req("R6 R13", 1'b0);
        drive(32'hE000_2000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0055_2000);
        chk("R6 high with erl tlbreq", {31'b0, tlb_req}, 32'd1);
        chk("R6 high paddr", xlat_paddr, 32'h0055_2000);
        finish_req("R6 high", 1'b0);
    endtask

    task automatic t_tlb_miss;
        drive(32'h7FFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0);
        chk("R7 load code", {27'b0, fault_code}, 32'd2);
        chk("R7 refill", {31'b0, fault_refill}, 32'd1);
        finish_req("R7 R10 R11 R12", 1'b1);
        drive(32'hC000_1F00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0);
        chk("R7 store code", {27'b0, fault_code}, 32'd3);
        chk("R7 store refill", {31'b0, fault_refill}, 32'd1);
        finish_req("R7 R12 gap", 1'b1);
    endtask

    task automatic t_tlb_invalid;
        drive(32'h0ABC_D123, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0);
        chk("R8 store code", {27'b0, fault_code}, 32'd3);
        chk("R8 refill clear", {30'b0, fault, fault_refill}, 32'b10);
        finish_req("R8 R11", 1'b1);
        drive(32'hF0F0_0000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0);
        chk("R8 load code", {27'b0, fault_code}, 32'd2);
        finish_req("R8 R12", 1'b1);
    endtask

    task automatic t_tlb_mod;
        drive(32'h0000_3008, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_3008);
        chk("R9 store code", {27'b0, fault_code}, 32'd1);
        chk("R9 refill/ok", {30'b0, fault_refill, xlat_ok}, 32'd0);
        finish_req("R9 R10", 1'b1);
        drive(32'h0000_3008, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0001_3008);
        chk("R9 load ok", {30'b0, xlat_ok, fault}, 32'b10);
        chk("R9 load paddr", xlat_paddr, 32'h0001_3008);
        finish_req("R9 load R13", 1'b0);
    endtask

    task automatic t_idle_hold;
        @(negedge clk);
        req_valid = 1'b0; req_vaddr = 32'h0000_0000; tlb_match = 1'b0;
        #1;
        chk("R13 idle no fault", {30'b0, fault, xlat_ok}, 32'd0);
        finish_req("R13 idle", 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_user_adderr;
                t_erl_identity;
                t_kseg;
                t_tlb_hit;
                t_tlb_miss;
                t_tlb_invalid;
                t_tlb_mod;
                t_idle_hold;
            end
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule